// File: doc/BRIEF.md
# I2C Slave Address Recognizer with General Call

This block is the receive side of an I2C slave. It filters the raw SCL and SDA lines through a two-flop synchronizer and watches them for START and STOP conditions. After each START it collects the first byte and checks it two ways. One check is against an address register that software loads. The other is against the all-zero general call byte, and that check is gated by an enable input. When a check matches, the block pulls SDA low for the acknowledge clock. It then takes in the data bytes that follow.

Every acknowledged byte, including the address byte, is copied into a receive buffer and sets a buffer-full flag. Because the address byte stays in the buffer, software can read it back and see whether it was addressed directly or by a general call (value zero). An interrupt flag marks each accepted byte. Reading the buffer clears buffer-full, and a separate strobe clears the interrupt flag.

In 10-bit mode, the first address byte matches and sets an update request, and software then reloads the register for the second byte. A general call in 10-bit mode skips that step and moves straight to data. A byte that arrives while the buffer is still full is refused (no ACK), and an overflow flag is raised.

Top module: `i2c_gc_slave_rx`

## Requirements
- R1: A START is SDA falling while SCL is high, and it begins address reception from any state, including a repeated START inside a transfer. A STOP is SDA rising while SCL is high, and it returns the block to idle. In idle, clocked bytes get no ACK.
- R2: In 7-bit mode (`mode10`=0), a first byte whose bits 7:1 equal address register bits 7:1 and whose bit 0 (R/W) is 0 gets an ACK. The ACK is `sda_oe`=1 during the ninth SCL clock. The byte is copied to `rx_buf` and `buf_full` is set.
- R3: With `gc_en`=1, a first byte of 0x00 gets an ACK and leaves 0x00 in `rx_buf`. With `gc_en`=0, the same byte gets no ACK unless the address register bits 7:1 are all zero.
- R4: A first byte that matches neither check gets no ACK. This includes an own address with R/W=1. `rx_buf`, `buf_full` and `irq` stay unchanged, and later bytes get no ACK until the next START.
- R5: After an acknowledged address phase, each data byte gets an ACK and is stored in `rx_buf`.
- R6: `buf_full` rises on the SCL rising edge of the eighth bit of an accepted byte, before the ACK clock.
- R7: `irq` is set on the SCL falling edge that ends the ninth clock of an accepted byte. It stays set until an `irq_clr` strobe.
- R8: A byte that completes while `buf_full` is set gets no ACK. It leaves `rx_buf` unchanged and sets `ovf`. A `buf_rd` strobe clears `buf_full`, and an `ovf_clr` strobe clears `ovf`.
- R9: In 10-bit mode, a first byte of the form 11110xx0 that equals the address register gets an ACK and sets `upd_addr`. The second byte gets an ACK only if it equals the register contents at that time. A register write clears `upd_addr`.
- R10: In 10-bit mode with `gc_en`=1, a 0x00 first byte gets an ACK without setting `upd_addr`. The next byte is taken as data.
- R11: `sda_oe` changes only while SCL is low. It is released on the falling edge that ends the ACK clock. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | Pulls SDA low when 1 (open drain) |
| gc_en | input | 1 | General call recognition enable |
| mode10 | input | 1 | 1 selects 10-bit addressing |
| addr_we | input | 1 | Write strobe for the address register |
| addr_wdata | input | 8 | Address register write data |
| buf_rd | input | 1 | Buffer read strobe, clears buffer-full |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| rx_buf | output | 8 | Last accepted byte |
| buf_full | output | 1 | Buffer holds an unread byte |
| irq | output | 1 | Byte accepted interrupt flag |
| ovf | output | 1 | Byte refused because buffer was full |
| upd_addr | output | 1 | 10-bit mode: reload address for second byte |

## Verification
The bench checks that the all-zero byte is acknowledged only while general call is enabled. A design that compared the general call unconditionally would acknowledge the zero byte even with the enable clear. In 10-bit mode it confirms that a general call neither raises the update request nor waits for a second address byte. It also checks that a second byte is refused when the register was not reloaded. The bench samples `buf_full` between the eighth rising edge and the ACK clock, and `irq` both before and after the ninth falling edge, so a flag set one phase early or late fails. Two further cases are covered. An overflow must leave the buffer untouched. An own address with R/W=1 must not be acknowledged.

// File: rtl/i2c_gc_slave_rx.sv
module i2c_gc_slave_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       gc_en,
  input  logic       mode10,
  input  logic       addr_we,
  input  logic [7:0] addr_wdata,
  input  logic       buf_rd,
  input  logic       irq_clr,
  input  logic       ovf_clr,
  output logic [7:0] rx_buf,
  output logic       buf_full,
  output logic       irq,
  output logic       ovf,
  output logic       upd_addr
);
  typedef enum logic [2:0] {S_IDLE, S_ADR1, S_ADR2, S_DATA, S_SKIP} st_t;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;
  logic [7:0] own_addr, shreg;
  logic [3:0] cnt;
  logic       ack_pend;
  st_t        st;

  wire scl_s = scl_ff[1];
  wire sda_s = sda_ff[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire bus_start = scl_s & scl_q & sda_q & ~sda_s;
  wire bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
  wire active    = (st == S_ADR1) || (st == S_ADR2) || (st == S_DATA);

  wire [7:0] byte_in = {shreg[6:0], sda_s};

  wire gc_hit  = (st == S_ADR1) && gc_en && (byte_in == 8'h00);
  wire own7    = (st == S_ADR1) && !mode10 && !byte_in[0] &&
                 (byte_in[7:1] == own_addr[7:1]);
  wire own10a  = (st == S_ADR1) && mode10 && !byte_in[0] &&
                 (byte_in[7:3] == 5'b11110) && (byte_in == own_addr);
  wire own10b  = (st == S_ADR2) && (byte_in == own_addr);
  wire take    = gc_hit | own7 | own10a | own10b | (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= 4'd0;
      shreg    <= 8'h00;
      own_addr <= 8'h00;
      rx_buf   <= 8'h00;
      buf_full <= 1'b0;
      irq      <= 1'b0;
      ovf      <= 1'b0;
      upd_addr <= 1'b0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      if (addr_we) begin
        own_addr <= addr_wdata;
        upd_addr <= 1'b0;
      end
      if (buf_rd)  buf_full <= 1'b0;
      if (irq_clr) irq      <= 1'b0;
      if (ovf_clr) ovf      <= 1'b0;

      if (bus_start) begin
        st       <= S_ADR1;
        cnt      <= 4'd0;
        ack_pend <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (bus_stop) begin
        st       <= S_IDLE;
        cnt      <= 4'd0;
        ack_pend <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (active) begin
        if (scl_rise && cnt < 4'd8) begin
          shreg <= byte_in;
          cnt   <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            if (!take) begin
              st <= S_SKIP;
            end else if (buf_full) begin
              ovf <= 1'b1;
              st  <= S_SKIP;
            end else begin
              rx_buf   <= byte_in;
              buf_full <= 1'b1;
              ack_pend <= 1'b1;
              if (own10a && !gc_hit) begin
                upd_addr <= 1'b1;
                st       <= S_ADR2;
              end else begin
                st <= S_DATA;
              end
            end
          end
        end else if (scl_fall && cnt == 4'd8) begin
          sda_oe <= ack_pend;
          cnt    <= 4'd9;
        end else if (scl_rise && cnt == 4'd9) begin
          cnt <= 4'd10;
        end else if (scl_fall && cnt == 4'd10) begin
          sda_oe   <= 1'b0;
          if (ack_pend) irq <= 1'b1;
          ack_pend <= 1'b0;
          cnt      <= 4'd0;
        end
      end
    end
  end

  // R11
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R7
  irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(scl_q) && !$past(scl_s)));

  // R6
  bf_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> ($past(scl_s) && !$past(scl_q)));

  // R8
  ovf_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $stable(rx_buf));

  // R10
  ua_not_gc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_addr) |-> (rx_buf[7:3] == 5'b11110));
endmodule

// File: tb/test_i2c_gc_slave_rx.sv
module test_i2c_gc_slave_rx;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic gc_en = 1'b0, mode10 = 1'b0;
  logic addr_we = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] addr_wdata = 8'h00;
  logic sda_oe, buf_full, irq, ovf, upd_addr;
  logic [7:0] rx_buf;
  wire sda_line = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic ack_got, bf8, irq_mid, irq_end, oe_end;

  always #2.5 clk = ~clk;

  i2c_gc_slave_rx i_i2c_gc_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .gc_en(gc_en), .mode10(mode10), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .buf_rd(buf_rd), .irq_clr(irq_clr), .ovf_clr(ovf_clr), .rx_buf(rx_buf),
    .buf_full(buf_full), .irq(irq), .ovf(ovf), .upd_addr(upd_addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: buf_rd = 1'b1;
      1: irq_clr = 1'b1;
      default: ovf_clr = 1'b1;
    endcase
    @(negedge clk);
    buf_rd = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic sw_clear();
    strobe(0);
    strobe(1);
  endtask

  task automatic wr_addr(input logic [7:0] v);
    @(negedge clk); addr_we = 1'b1; addr_wdata = v;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic i2c_start();
    scl_m = 1'b0; wq();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    scl_m = 1'b0; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wq();
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      if (i == 0) bf8 = buf_full;
      wq();
    end
    scl_m = 1'b0; wq();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack_got = ~sda_line;
    irq_mid = irq;
    wq();
    scl_m = 1'b0; wq();
    irq_end = irq;
    oe_end = sda_oe;
  endtask

  task automatic t_reset();
    chk("R11 reset sda_oe", sda_oe, 0);
    chk("R6 reset buf_full", buf_full, 0);
    chk("R7 reset irq", irq, 0);
    chk("R8 reset ovf", ovf, 0);
    chk("R9 reset upd_addr", upd_addr, 0);
  endtask

  task automatic t_own7();
    mode10 = 0; gc_en = 0; wr_addr(8'h84);
    i2c_start(); send_byte(8'h84);
    chk("R2 own ack", ack_got, 1);
    chk("R2 buf", rx_buf, 8'h84);
    chk("R6 bf at 8th rise", bf8, 1);
    chk("R7 irq not before 9th fall", irq_mid, 0);
    chk("R7 irq after 9th fall", irq_end, 1);
    chk("R11 released after ack", oe_end, 0);
    strobe(0);
    chk("R8 read clears bf", buf_full, 0);
    chk("R7 irq held until clear", irq, 1);
    strobe(1);
    chk("R7 irq cleared", irq, 0);
    send_byte(8'h5A);
    chk("R5 data ack", ack_got, 1);
    chk("R5 data buf", rx_buf, 8'h5A);
    sw_clear();
    send_byte(8'hA5);
    chk("R5 second data", rx_buf, 8'hA5);
    sw_clear();
    i2c_stop();
    send_byte(8'h84);
    chk("R1 idle after stop no ack", ack_got, 0);
    chk("R1 idle no bf", buf_full, 0);
    i2c_stop();
  endtask

  task automatic t_mismatch();
    i2c_start(); send_byte(8'h86);
    chk("R4 mismatch nack", ack_got, 0);
    chk("R4 mismatch bf", buf_full, 0);
    chk("R4 mismatch irq", irq_end, 0);
    chk("R4 mismatch buf", rx_buf, 8'hA5);
    send_byte(8'h84);
    chk("R4 skip until start", ack_got, 0);
    i2c_start(); send_byte(8'h85);
    chk("R4 read bit nack", ack_got, 0);
    i2c_start(); send_byte(8'h84);
    chk("R1 repeated start ack", ack_got, 1);
    sw_clear();
    i2c_stop();
  endtask

  task automatic t_gc();
    gc_en = 0;
    i2c_start(); send_byte(8'h00);
    chk("R3 gc disabled nack", ack_got, 0);
    chk("R3 gc disabled bf", buf_full, 0);
    gc_en = 1;
    i2c_start(); send_byte(8'h00);
    chk("R3 gc ack", ack_got, 1);
    chk("R3 gc buf zero", rx_buf, 8'h00);
    sw_clear();
    send_byte(8'h33);
    chk("R5 gc data", rx_buf, 8'h33);
    sw_clear();
    i2c_stop();
    gc_en = 0;
  endtask

  task automatic t_ovf();
    i2c_start(); send_byte(8'h84);
    chk("R2 addr before ovf", ack_got, 1);
    send_byte(8'hC3);
    chk("R8 ovf nack", ack_got, 0);
    chk("R8 ovf flag", ovf, 1);
    chk("R8 buf kept", rx_buf, 8'h84);
    strobe(0);
    chk("R8 bf cleared", buf_full, 0);
    strobe(2);
    chk("R8 ovf cleared", ovf, 0);
    strobe(1);
    i2c_stop();
  endtask

  task automatic t_ten();
    mode10 = 1; gc_en = 0; wr_addr(8'hF2);
    i2c_start(); send_byte(8'hF2);
    chk("R9 first byte ack", ack_got, 1);
    chk("R9 ua set", upd_addr, 1);
    sw_clear();
    wr_addr(8'h3C);
    chk("R9 ua cleared by write", upd_addr, 0);
    send_byte(8'h3C);
    chk("R9 second byte ack", ack_got, 1);
    chk("R9 second byte buf", rx_buf, 8'h3C);
    sw_clear();
    send_byte(8'h77);
    chk("R5 10b data", rx_buf, 8'h77);
    sw_clear();
    i2c_stop();
    wr_addr(8'hF2);
    i2c_start(); send_byte(8'hF2);
    sw_clear();
    send_byte(8'h3C);
    chk("R9 no reload nack", ack_got, 0);
    i2c_stop();
    wr_addr(8'hF2);
  endtask

  task automatic t_ten_gc();
    mode10 = 1; gc_en = 1;
    i2c_start(); send_byte(8'h00);
    chk("R10 gc ack", ack_got, 1);
    chk("R10 no ua", upd_addr, 0);
    sw_clear();
    send_byte(8'h99);
    chk("R10 data ack", ack_got, 1);
    chk("R10 data buf", rx_buf, 8'h99);
    sw_clear();
    i2c_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_own7();
    t_mismatch();
    t_gc();
    t_ovf();
    t_ten();
    t_ten_gc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule